// File: doc/BRIEF.md
# Link Power-Status Monitor and Wake Controller

This block sits on the physical-layer side of the PHY/link interface and watches the power-status level driven by the link-layer controller. It counts, on the system clock, how long that level stays low after a two-flop synchronizer. A low interval shorter than the short threshold counts as a glitch and has no effect. An interval that reaches the short threshold but ends before the long threshold produces a one-cycle interface-reset pulse when the level returns high. An interval that reaches the long threshold drops the interface-enable output, so the interface is powered down. The repeater path lives elsewhere and keeps working.

While the interface is down, a link-on packet indication starts a wake clock toward the link layer. The clock is the system clock divided by a parameter, 49.152 MHz / 8 ≈ 6.144 MHz by default. It runs until the link-control bit is set, and is held low whenever it is inactive. The interface is enabled again once two consecutive synchronized samples of the status level are high.

Top module: `link_power_monitor`

## Requirements
- R1: After synchronous reset, `phy_if_enable` is 1, `phy_if_reset` is 0 and `wake_clk` is 0.
- R2: `lps_in` passes through two flops before the low-time counter sees it. For a low interval of N cycles, an issued reset pulse appears exactly N+3 clock edges after `lps_in` fell.
- R3: A synchronized low interval of fewer than SHORT_CYC cycles causes no reset pulse and leaves `phy_if_enable` at 1.
- R4: A synchronized low interval of at least SHORT_CYC and at most LONG_CYC-1 cycles, while enabled, gives exactly one `phy_if_reset` pulse, one cycle wide, and `phy_if_enable` stays 1.
- R5: When the synchronized low interval reaches LONG_CYC cycles, `phy_if_enable` falls LONG_CYC+2 edges after `lps_in` fell. No reset pulse follows the later return high.
- R6: While disabled, `phy_if_enable` returns to 1 only after two consecutive high synchronized samples, i.e. 4 edges after `lps_in` rises. A single high sample leaves it at 0.
- R7: A one-cycle `linkon_pkt` while disabled starts `wake_clk`. Its first rising edge comes DIV/2+1 edges later, it stays high for DIV/2 cycles and its period is DIV cycles.
- R8: `linkon_pkt` has no effect on `wake_clk` while the interface is enabled.
- R9: `lctrl_bit` high stops the wake clock. `wake_clk` is 0 two edges later and stays 0. `lctrl_bit` takes priority over a simultaneous `linkon_pkt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 49.152 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| lps_in | input | 1 | Link power-status level from the link layer (asynchronous) |
| linkon_pkt | input | 1 | One-cycle indication that a link-on packet was received |
| lctrl_bit | input | 1 | Link-control bit; high cancels the wake clock |
| phy_if_reset | output | 1 | One-cycle PHY/link interface reset pulse |
| phy_if_enable | output | 1 | PHY/link interface enable level |
| wake_clk | output | 1 | Wake clock toward the link layer; low when inactive |

## Verification
A wrong low-time count shows at the ports in one of three ways. A reset pulse may appear at the wrong edge, or for an interval on the wrong side of a threshold. Or `phy_if_enable` may fall one cycle early or late. All of these are visible within three edges of the status level returning high, or at the long-threshold edge itself. A corrupted enable state shows as a missed or extra re-enable four edges after the level rises. A stuck wake state shows as a clock that does not start DIV/2+1 edges after the link-on indication, or one that is still toggling two edges after the control bit is set. The intervals around each threshold, one cycle below and at the threshold, are driven so that an off-by-one in any comparison changes what the ports show.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic {
    LINK_UP  = 1'b0,
    LINK_OFF = 1'b1
  } link_st_e;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/lpm_lowtimer.sv
module lpm_lowtimer
  import lpm_pkg::*;
#(
  parameter int SHORT_CYC = 59,
  parameter int LONG_CYC  = 1229
) (
  input  logic clk,
  input  logic rst,
  input  logic lps_s,
  output logic if_reset,
  output logic if_enable
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);
  localparam logic [CW-1:0] LAST_V  = CW'(LONG_CYC - 1);

  link_st_e        state;
  logic [CW-1:0]   low_cnt;
  logic            hi_seen;
  logic            pulse_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LINK_UP;
      low_cnt <= '0;
      hi_seen <= 1'b0;
      pulse_r <= 1'b0;
    end else begin
      pulse_r <= 1'b0;
      if (!lps_s) begin
        hi_seen <= 1'b0;
        if (low_cnt != LONG_V) low_cnt <= low_cnt + 1'b1;
        if (low_cnt == LAST_V && state == LINK_UP) state <= LINK_OFF;
      end else begin
        low_cnt <= '0;
        if (state == LINK_UP) begin
          hi_seen <= 1'b0;
          if (low_cnt >= SHORT_V && low_cnt < LONG_V) pulse_r <= 1'b1;
        end else if (hi_seen) begin
          state   <= LINK_UP;
          hi_seen <= 1'b0;
        end else begin
          hi_seen <= 1'b1;
        end
      end
    end
  end

  assign if_reset  = pulse_r;
  assign if_enable = (state == LINK_UP);

  p_pulse_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    if_reset |=> !if_reset);
  p_pulse_when_up_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(if_reset) |-> if_enable);
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= LONG_V);
  p_off_while_low_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(if_enable) |-> !$past(lps_s));
  p_reenable_two_high_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(if_enable) |-> ($past(lps_s, 1) && $past(lps_s, 2)));
endmodule

// File: rtl/lpm_wakediv.sv
module lpm_wakediv #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  input  logic link_off,
  output logic wake_clk
);
  localparam int HALF = DIV / 2;
  localparam int DW   = $clog2(DIV);
  localparam logic [DW-1:0] HALF_M1 = DW'(HALF - 1);
  localparam logic [DW-1:0] DIV_M1  = DW'(DIV - 1);

  logic          wake_act;
  logic [DW-1:0] div_cnt;
  logic          clk_r;

  always_ff @(posedge clk) begin
    if (rst)                    wake_act <= 1'b0;
    else if (stop)              wake_act <= 1'b0;
    else if (start && link_off) wake_act <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !wake_act) begin
      div_cnt <= '0;
      clk_r   <= 1'b0;
    end else begin
      div_cnt <= (div_cnt == DIV_M1) ? '0 : div_cnt + 1'b1;
      if (div_cnt == HALF_M1 || div_cnt == DIV_M1) clk_r <= ~clk_r;
    end
  end

  assign wake_clk = clk_r;

  p_stop_wins_r9: assert property (@(posedge clk) disable iff (rst)
    stop |=> !wake_act);
  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !wake_act |=> !wake_clk);
  p_no_start_enabled_r8: assert property (@(posedge clk) disable iff (rst)
    (!wake_act && !link_off) |=> !wake_act);
endmodule

// File: rtl/link_power_monitor.sv
module link_power_monitor #(
  parameter int SHORT_CYC   = 59,
  parameter int LONG_CYC    = 1229,
  parameter int DIV         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lps_in,
  input  logic linkon_pkt,
  input  logic lctrl_bit,
  output logic phy_if_reset,
  output logic phy_if_enable,
  output logic wake_clk
);
  logic lps_s;

  lpm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d_in(lps_in), .d_out(lps_s)
  );

  lpm_lowtimer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) i_timer (
    .clk(clk), .rst(rst), .lps_s(lps_s),
    .if_reset(phy_if_reset), .if_enable(phy_if_enable)
  );

  lpm_wakediv #(.DIV(DIV)) i_wake (
    .clk(clk), .rst(rst), .start(linkon_pkt), .stop(lctrl_bit),
    .link_off(!phy_if_enable), .wake_clk(wake_clk)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (phy_if_enable && !phy_if_reset && !wake_clk));
endmodule

// File: tb/test_link_power_monitor.sv
module test_link_power_monitor;
  localparam int SHORT = 59;
  localparam int LONG  = 1229;
  localparam int DIV   = 8;
  localparam int HALF  = DIV / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lps_in = 1'b1;
  logic linkon_pkt = 1'b0;
  logic lctrl_bit = 1'b0;
  logic phy_if_reset, phy_if_enable, wake_clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_power_monitor #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .DIV(DIV)) i_link_power_monitor (
    .clk(clk), .rst(rst), .lps_in(lps_in), .linkon_pkt(linkon_pkt),
    .lctrl_bit(lctrl_bit), .phy_if_reset(phy_if_reset),
    .phy_if_enable(phy_if_enable), .wake_clk(wake_clk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every reset pulse must match the next expected edge (R2, R4).
  always @(negedge clk) begin
    if (!rst && phy_if_reset) begin
      if (exp_q.size() == 0) check("R3/R5 unexpected reset pulse", cyc, -1);
      else check("R2/R4 reset pulse edge", cyc, exp_q.pop_front());
    end
  end

  task automatic low_pulse(input int n);
    int c0;
    @(negedge clk);
    c0 = cyc;
    lps_in = 1'b0;
    repeat (n) @(negedge clk);
    lps_in = 1'b1;
    if (n >= SHORT && n < LONG) exp_q.push_back(c0 + n + 3);
    repeat (8) @(negedge clk);
  endtask

  task automatic idle_wake(input string req, input int n);
    int hit = 0;
    repeat (n) begin
      @(negedge clk);
      if (wake_clk) hit++;
    end
    check(req, hit, 0);
  endtask

  initial begin
    int c0, t_r1, t_r2, t_f1;
    logic prev;
    repeat (3) @(negedge clk);
    check("R1 enable", phy_if_enable, 1);
    check("R1 wake", wake_clk, 0);
    check("R1 reset pulse", phy_if_reset, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 enable after release", phy_if_enable, 1);

    low_pulse(1);
    low_pulse(SHORT - 1);
    check("R3 enable kept", phy_if_enable, 1);
    low_pulse(SHORT);
    low_pulse(LONG - 1);
    check("R4 enable kept", phy_if_enable, 1);
    check("R4 pulses consumed", exp_q.size(), 0);

    // R5: long low interval
    @(negedge clk);
    lps_in = 1'b0;
    repeat (LONG + 1) @(posedge clk);
    @(negedge clk);
    check("R5 enable before threshold", phy_if_enable, 1);
    @(negedge clk);
    check("R5 enable at threshold", phy_if_enable, 0);
    repeat (20) @(negedge clk);

    // R6: one high sample does not re-enable
    lps_in = 1'b1;
    @(negedge clk);
    lps_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 single high sample", phy_if_enable, 0);

    // R7: wake clock
    c0 = cyc;
    linkon_pkt = 1'b1;
    @(negedge clk);
    linkon_pkt = 1'b0;
    t_r1 = -1; t_r2 = -1; t_f1 = -1;
    prev = wake_clk;
    repeat (4 * DIV) begin
      if (!prev && wake_clk) begin
        if (t_r1 < 0) t_r1 = cyc; else if (t_r2 < 0) t_r2 = cyc;
      end
      if (prev && !wake_clk && t_f1 < 0) t_f1 = cyc;
      prev = wake_clk;
      @(negedge clk);
    end
    check("R7 first rise", t_r1 - c0, HALF + 1);
    check("R7 high time", t_f1 - t_r1, HALF);
    check("R7 period", t_r2 - t_r1, DIV);

    // R9: control bit stops it
    lctrl_bit = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 stopped after two edges", wake_clk, 0);
    idle_wake("R9 stays low", 3 * DIV);
    linkon_pkt = 1'b1;
    @(negedge clk);
    linkon_pkt = 1'b0;
    idle_wake("R9 priority over link-on", 3 * DIV);
    lctrl_bit = 1'b0;

    // R6: re-enable after two high samples, no pulse (R5)
    @(negedge clk);
    lps_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 still disabled after 3 edges", phy_if_enable, 0);
    @(negedge clk);
    check("R6 enabled after 4 edges", phy_if_enable, 1);
    repeat (10) @(negedge clk);
    check("R5 no pulse on recovery", exp_q.size(), 0);

    // R8: link-on while enabled
    linkon_pkt = 1'b1;
    @(negedge clk);
    linkon_pkt = 1'b0;
    idle_wake("R8 ignored while enabled", 3 * DIV);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule